// File: doc/BRIEF.md
# Cascade Ring Message Gateway

This block links several CAN message cells through one wide, daisy-chained cascade ring. Every cell holds a single-ported message store and two full-width record registers: one that the CPU uses, and one that the ring uses. A record is the complete header, payload and control word of one message object. On request, a routing state machine copies one record from a source cell to one or more destination cells. No CPU bus cycles are spent on the copy. The copy has three steps. First, the source cell reads the record into its ring register. Next, that cell drives the ring for one cycle while every other cell passes the ring through, and each chosen destination latches the record in the same cycle. Last, every destination commits the record to its store at the requested message number.

The CPU keeps direct access to every cell while transfers run. It issues one-cycle read or write strobes to a cell and gets an acknowledge pulse when the operation completes. When the CPU and the router want the same cell's message handler in the same cycle, fixed priority decides: the CPU goes first. An operation that a handler has already started is always finished before the next one begins. No semaphores or flags are involved.

Top module: `ring_gateway`

## Requirements
- R1: While reset is asserted and right after it is released, `xfer_ready` is 1 and `xfer_done`, `xfer_err`, `cpu_ack` and `cell_busy` are all 0.
- R2: A CPU strobe with `cpu_wr`=1 stores `cpu_wdata` at message `cpu_msg` of cell `cpu_cell`. A strobe with `cpu_wr`=0 returns that record on `cpu_rdata` in the single cycle in which `cpu_ack` pulses.
- R3: An accepted transfer writes the record held at message `xfer_src_msg` of cell `xfer_src` into message `xfer_dst_msg` of every cell whose bit is set in `xfer_dst_mask`. Bit i of the mask stands for cell i. Destinations may sit above or below the source on the ring, and the source itself may be one of them.
- R4: A transfer leaves unchanged every cell whose mask bit is 0. Messages other than the destination message number are also left unchanged.
- R5: A request with an all-zero destination mask produces a one-cycle `xfer_err` pulse in the cycle after the accepting edge. It produces no `xfer_done`, modifies no cell, and leaves `xfer_ready` at 1.
- R6: With no CPU contention, `xfer_done` pulses for one cycle, exactly 2*CMD_LAT+3 clock edges after the edge that accepts the request.
- R7: When a CPU strobe reaches a cell in the same cycle as the router's request to that cell, the CPU operation is served first. The transfer still delivers the correct record, and `xfer_done` comes 3*CMD_LAT+4 edges after acceptance. The CPU acknowledge arrives before that.
- R8: A CPU strobe to a cell that is executing a router operation waits until that operation finishes. Both results are kept, and `xfer_done` precedes `cpu_ack`.
- R9: Requests made while `xfer_ready` is 0 are ignored. They cause no extra `xfer_done` and modify no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Transfer request strobe, taken when `xfer_ready` is 1 |
| xfer_src | input | $clog2(NCELL) | Source cell index |
| xfer_src_msg | input | $clog2(NMSG) | Source message number |
| xfer_dst_mask | input | NCELL | Destination cells, bit i = cell i |
| xfer_dst_msg | input | $clog2(NMSG) | Destination message number |
| xfer_ready | output | 1 | Router idle, request accepted |
| xfer_done | output | 1 | One-cycle transfer completion pulse |
| xfer_err | output | 1 | One-cycle pulse for an empty destination mask |
| cpu_req | input | 1 | CPU command strobe |
| cpu_cell | input | $clog2(NCELL) | Target cell of the CPU command |
| cpu_wr | input | 1 | 1 = write record, 0 = read record |
| cpu_msg | input | $clog2(NMSG) | Message number of the CPU command |
| cpu_wdata | input | REC_W | Record written by the CPU |
| cpu_ack | output | 1 | One-cycle CPU completion pulse |
| cpu_rdata | output | REC_W | Record read, valid while `cpu_ack` is 1 |
| cell_busy | output | NCELL | Message handler of each cell occupied |

## Verification
The hardest cases to reach from the ports are the two arbitration collisions. In one, a CPU strobe and a router request meet at the same idle handler in the same cycle. In the other, a CPU strobe reaches a handler in the middle of a router operation. For the first, the stimulus raises `xfer_req` and a CPU read of the source cell on the same clock edge, which makes them collide in the source's first handler cycle. For the second, the stimulus watches `cell_busy` of a destination-only cell. That bit can rise only in the commit phase, so the CPU write strobe is launched at that moment. In both cases the bench compares the edge counts of `cpu_ack` and `xfer_done` and then reads back every affected record.

// File: rtl/ringgw_pkg.sv
package ringgw_pkg;

  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_SRC   = 2'd1,
    RT_BCAST = 2'd2,
    RT_DST   = 2'd3
  } rt_state_e;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_GW  = 1'b1
  } owner_e;

endpackage

// File: rtl/gw_cell.sv
module gw_cell
  import ringgw_pkg::*;
#(
  parameter int NMSG    = 8,
  parameter int REC_W   = 96,
  parameter int CMD_LAT = 3,
  localparam int MSG_W  = (NMSG > 1) ? $clog2(NMSG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stb,
  input  logic             cpu_wr,
  input  logic [MSG_W-1:0] cpu_msg,
  input  logic [REC_W-1:0] cpu_wdata,
  output logic             cpu_ack,
  output logic [REC_W-1:0] cpu_rec,
  input  logic             gw_req,
  input  logic             gw_wr,
  input  logic [MSG_W-1:0] gw_msg,
  output logic             gw_done,
  input  logic             ring_ld,
  input  logic [REC_W-1:0] ring_in,
  output logic [REC_W-1:0] gw_rec,
  output logic             busy
);

  localparam int CNT_W = $clog2(CMD_LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_LAT - 1);

  logic [REC_W-1:0] ram [NMSG];

  logic             hbusy_q, hbusy_d;
  owner_e           own_q, own_d;
  logic             opwr_q, opwr_d;
  logic [MSG_W-1:0] opmsg_q, opmsg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             cwr_q;
  logic [MSG_W-1:0] cmsg_q;
  logic             ack_q;
  logic [REC_W-1:0] cset_q, gset_q;
  logic [REC_W-1:0] ram_rd;
  logic             cpu_take, gw_take, finish;

  // fixed priority: a pending or arriving CPU command blocks the router
  assign cpu_take = !hbusy_q && pend_q;
  assign gw_take  = !hbusy_q && !pend_q && !cpu_stb && gw_req;
  assign finish   = hbusy_q && (cnt_q == LAST);
  assign ram_rd   = ram[opmsg_q];

  always_comb begin
    hbusy_d = hbusy_q;
    own_d   = own_q;
    opwr_d  = opwr_q;
    opmsg_d = opmsg_q;
    cnt_d   = cnt_q;
    pend_d  = (pend_q && !cpu_take) || cpu_stb;
    if (hbusy_q) begin
      if (finish) hbusy_d = 1'b0;
      else        cnt_d   = cnt_q + CNT_W'(1);
    end else if (cpu_take) begin
      hbusy_d = 1'b1;
      own_d   = OWN_CPU;
      opwr_d  = cwr_q;
      opmsg_d = cmsg_q;
      cnt_d   = '0;
    end else if (gw_take) begin
      hbusy_d = 1'b1;
      own_d   = OWN_GW;
      opwr_d  = gw_wr;
      opmsg_d = gw_msg;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbusy_q <= 1'b0;
      own_q   <= OWN_CPU;
      opwr_q  <= 1'b0;
      opmsg_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
      cwr_q   <= 1'b0;
      cmsg_q  <= '0;
    end else begin
      hbusy_q <= hbusy_d;
      own_q   <= own_d;
      opwr_q  <= opwr_d;
      opmsg_q <= opmsg_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ack_q   <= finish && (own_q == OWN_CPU);
      if (cpu_stb) begin
        cwr_q  <= cpu_wr;
        cmsg_q <= cpu_msg;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (finish && (own_q == OWN_CPU) && !opwr_q) cset_q <= ram_rd;
    else if (cpu_stb && cpu_wr)                  cset_q <= cpu_wdata;
    if (finish && (own_q == OWN_GW) && !opwr_q)  gset_q <= ram_rd;
    else if (ring_ld)                            gset_q <= ring_in;
  end

  always_ff @(posedge clk) begin
    if (finish && opwr_q) ram[opmsg_q] <= (own_q == OWN_CPU) ? cset_q : gset_q;
  end

  assign cpu_ack = ack_q;
  assign cpu_rec = cset_q;
  assign gw_rec  = gset_q;
  assign gw_done = finish && (own_q == OWN_GW);
  assign busy    = hbusy_q;

  // R7: CPU wins a tie at an idle handler
  assert_cpu_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hbusy_q && pend_q && gw_req) |=> (hbusy_q && own_q == OWN_CPU));

  // R8: a router operation runs to completion on the same message
  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hbusy_q && own_q == OWN_GW && !finish) |=> (hbusy_q && own_q == OWN_GW && $stable(opmsg_q)));

  // R2: acknowledge is a single-cycle pulse
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

endmodule

// File: rtl/gw_ring.sv
module gw_ring #(
  parameter int NCELL = 4,
  parameter int REC_W = 96
) (
  input  logic [NCELL-1:0]            drive,
  input  logic [NCELL-1:0][REC_W-1:0] cell_rec,
  output logic [NCELL-1:0][REC_W-1:0] ring_in
);

  // Output muxes of all cells: a cell either drives its record or forwards
  // its input. Walked twice round so cells upstream of the driver see it.
  always_comb begin
    logic [REC_W-1:0] cur;
    cur     = '0;
    ring_in = '0;
    for (int j = 0; j < 2 * NCELL; j++) begin
      if (j >= NCELL) ring_in[j - NCELL] = cur;
      if (drive[j % NCELL]) cur = cell_rec[j % NCELL];
    end
  end

endmodule

// File: rtl/gw_router.sv
module gw_router
  import ringgw_pkg::*;
#(
  parameter int NCELL  = 4,
  parameter int NMSG   = 8,
  localparam int CELL_W = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int MSG_W  = (NMSG > 1) ? $clog2(NMSG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic [CELL_W-1:0] xfer_src,
  input  logic [MSG_W-1:0]  xfer_src_msg,
  input  logic [NCELL-1:0]  xfer_dst_mask,
  input  logic [MSG_W-1:0]  xfer_dst_msg,
  input  logic [NCELL-1:0]  gw_done,
  output logic [NCELL-1:0]  gw_req,
  output logic              gw_wr,
  output logic [MSG_W-1:0]  gw_msg,
  output logic [NCELL-1:0]  drive,
  output logic [NCELL-1:0]  ring_ld,
  output logic              ready,
  output logic              done,
  output logic              err
);

  rt_state_e         st_q, st_d;
  logic [CELL_W-1:0] src_q, src_d;
  logic [MSG_W-1:0]  smsg_q, smsg_d;
  logic [MSG_W-1:0]  dmsg_q, dmsg_d;
  logic [NCELL-1:0]  mask_q, mask_d;
  logic [NCELL-1:0]  pend_q, pend_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [NCELL-1:0]  left;

  assign left = pend_q & ~gw_done;

  always_comb begin
    st_d   = st_q;
    src_d  = src_q;
    smsg_d = smsg_q;
    dmsg_d = dmsg_q;
    mask_d = mask_q;
    pend_d = pend_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      RT_IDLE: begin
        if (xfer_req) begin
          if (xfer_dst_mask == '0) begin
            err_d = 1'b1;
          end else begin
            src_d  = xfer_src;
            smsg_d = xfer_src_msg;
            dmsg_d = xfer_dst_msg;
            mask_d = xfer_dst_mask;
            pend_d = NCELL'(1) << xfer_src;
            st_d   = RT_SRC;
          end
        end
      end
      RT_SRC: begin
        pend_d = left;
        if (left == '0) st_d = RT_BCAST;
      end
      RT_BCAST: begin
        pend_d = mask_q;
        st_d   = RT_DST;
      end
      RT_DST: begin
        pend_d = left;
        if (left == '0) begin
          st_d   = RT_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = RT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RT_IDLE;
      src_q  <= '0;
      smsg_q <= '0;
      dmsg_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      smsg_q <= smsg_d;
      dmsg_q <= dmsg_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign gw_req  = (st_q == RT_SRC || st_q == RT_DST) ? pend_q : '0;
  assign gw_wr   = (st_q == RT_DST);
  assign gw_msg  = (st_q == RT_DST) ? dmsg_q : smsg_q;
  assign drive   = (st_q == RT_BCAST) ? (NCELL'(1) << src_q) : '0;
  assign ring_ld = (st_q == RT_BCAST) ? mask_q : '0;
  assign ready   = (st_q == RT_IDLE);
  assign done    = done_q;
  assign err     = err_q;

  // R5: empty mask answers with an error and no transfer
  assert_err_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && xfer_req && xfer_dst_mask == '0) |=> (err && !done && ready));

  // R6: completion is a single-cycle pulse and never coincides with an error
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9: requests during a transfer leave the latched route untouched
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && xfer_req) |=> ($stable(mask_q) && $stable(src_q) && $stable(dmsg_q)));

endmodule

// File: rtl/ring_gateway.sv
module ring_gateway
  import ringgw_pkg::*;
#(
  parameter int NCELL   = 4,
  parameter int NMSG    = 8,
  parameter int REC_W   = 96,
  parameter int CMD_LAT = 3,
  localparam int CELL_W = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int MSG_W  = (NMSG > 1) ? $clog2(NMSG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic [CELL_W-1:0] xfer_src,
  input  logic [MSG_W-1:0]  xfer_src_msg,
  input  logic [NCELL-1:0]  xfer_dst_mask,
  input  logic [MSG_W-1:0]  xfer_dst_msg,
  output logic              xfer_ready,
  output logic              xfer_done,
  output logic              xfer_err,
  input  logic              cpu_req,
  input  logic [CELL_W-1:0] cpu_cell,
  input  logic              cpu_wr,
  input  logic [MSG_W-1:0]  cpu_msg,
  input  logic [REC_W-1:0]  cpu_wdata,
  output logic              cpu_ack,
  output logic [REC_W-1:0]  cpu_rdata,
  output logic [NCELL-1:0]  cell_busy
);

  logic [1:0]             rst_pipe;
  logic                   rst_int_n;
  logic [NCELL-1:0]       gw_req, gw_done, drive, ring_ld, ack_v, stb_v;
  logic                   gw_wr;
  logic [MSG_W-1:0]       gw_msg;
  logic [NCELL-1:0][REC_W-1:0] gw_rec, cpu_rec, ring_in;
  logic [REC_W-1:0]       bcast_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  gw_router #(.NCELL(NCELL), .NMSG(NMSG)) u_router (
    .clk(clk), .rst_n(rst_int_n),
    .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_src_msg(xfer_src_msg),
    .xfer_dst_mask(xfer_dst_mask), .xfer_dst_msg(xfer_dst_msg),
    .gw_done(gw_done), .gw_req(gw_req), .gw_wr(gw_wr), .gw_msg(gw_msg),
    .drive(drive), .ring_ld(ring_ld),
    .ready(xfer_ready), .done(xfer_done), .err(xfer_err)
  );

  gw_ring #(.NCELL(NCELL), .REC_W(REC_W)) u_ring (
    .drive(drive), .cell_rec(gw_rec), .ring_in(ring_in)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign stb_v[i] = cpu_req && (cpu_cell == CELL_W'(i));

    gw_cell #(.NMSG(NMSG), .REC_W(REC_W), .CMD_LAT(CMD_LAT)) u_cell (
      .clk(clk), .rst_n(rst_int_n),
      .cpu_stb(stb_v[i]), .cpu_wr(cpu_wr), .cpu_msg(cpu_msg), .cpu_wdata(cpu_wdata),
      .cpu_ack(ack_v[i]), .cpu_rec(cpu_rec[i]),
      .gw_req(gw_req[i]), .gw_wr(gw_wr), .gw_msg(gw_msg), .gw_done(gw_done[i]),
      .ring_ld(ring_ld[i]), .ring_in(ring_in[i]), .gw_rec(gw_rec[i]),
      .busy(cell_busy[i])
    );

    // R3: every loading cell captures the record the driving cell presented
    assert_bcast_copy_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
      ring_ld[i] |=> (gw_rec[i] == $past(bcast_val)));
  end

  always_comb begin
    cpu_rdata = '0;
    cpu_ack   = 1'b0;
    bcast_val = '0;
    for (int i = 0; i < NCELL; i++) begin
      if (ack_v[i]) cpu_rdata = cpu_rdata | cpu_rec[i];
      cpu_ack = cpu_ack | ack_v[i];
      if (drive[i]) bcast_val = bcast_val | gw_rec[i];
    end
  end

  // R3: at most one cell drives the ring
  assert_one_driver_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(drive));

endmodule

// File: tb/test_ring_gateway.sv
`timescale 1ns/1ps
module test_ring_gateway;
  localparam int NCELL   = 4;
  localparam int NMSG    = 8;
  localparam int REC_W   = 96;
  localparam int CMD_LAT = 3;
  localparam int CW      = 2;
  localparam int MW      = 3;
  localparam int NOM_LAT = 2 * CMD_LAT + 3;
  localparam int PRI_LAT = 3 * CMD_LAT + 4;
  localparam int NVEC    = 6;
  // {source cell, source msg, destination mask, destination msg}
  localparam int VEC [NVEC][4] = '{
    '{0, 1, 4'b0010, 2},
    '{2, 3, 4'b1011, 5},
    '{3, 0, 4'b1111, 7},
    '{1, 6, 4'b0001, 0},
    '{0, 2, 4'b0100, 2},
    '{3, 5, 4'b0110, 4}
  };

  logic clk, rst_n;
  logic xfer_req; logic [CW-1:0] xfer_src; logic [MW-1:0] xfer_src_msg, xfer_dst_msg;
  logic [NCELL-1:0] xfer_dst_mask;
  logic xfer_ready, xfer_done, xfer_err;
  logic cpu_req, cpu_wr, cpu_ack; logic [CW-1:0] cpu_cell; logic [MW-1:0] cpu_msg;
  logic [REC_W-1:0] cpu_wdata, cpu_rdata;
  logic [NCELL-1:0] cell_busy;

  ring_gateway #(.NCELL(NCELL), .NMSG(NMSG), .REC_W(REC_W), .CMD_LAT(CMD_LAT)) i_ring_gateway (
    .clk(clk), .rst_n(rst_n),
    .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_src_msg(xfer_src_msg),
    .xfer_dst_mask(xfer_dst_mask), .xfer_dst_msg(xfer_dst_msg),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .cpu_req(cpu_req), .cpu_cell(cpu_cell), .cpu_wr(cpu_wr), .cpu_msg(cpu_msg),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .cell_busy(cell_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [REC_W-1:0] shadow [NCELL][NMSG];

  function automatic logic [REC_W-1:0] mkrec(int k);
    return {32'(k) * 32'h0100_0193, 32'hC0DE_0000 ^ 32'(k), ~32'(k * 7)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [REC_W-1:0] act,
                       input logic [REC_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input int c, input bit wr, input int m,
                        input logic [REC_W-1:0] wd, output logic [REC_W-1:0] rd);
    bit got = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_cell = CW'(c); cpu_wr = wr; cpu_msg = MW'(m); cpu_wdata = wd;
    rd = '0;
    for (int t = 0; t < 60; t++) begin
      @(posedge clk); @(negedge clk);
      cpu_req = 1'b0;
      if (cpu_ack) begin got = 1; rd = cpu_rdata; break; end
    end
    if (!got) check(0, "R2 cpu ack timeout", '0, 96'd1);
  endtask

  task automatic cpu_write(input int c, input int m, input logic [REC_W-1:0] wd);
    logic [REC_W-1:0] dummy;
    cpu_op(c, 1'b1, m, wd, dummy);
    shadow[c][m] = wd;
  endtask

  task automatic cpu_read(input int c, input int m, output logic [REC_W-1:0] rd);
    cpu_op(c, 1'b0, m, '0, rd);
  endtask

  task automatic set_xfer(input int s, input int sm, input int mk, input int dm);
    xfer_req = 1'b1; xfer_src = CW'(s); xfer_src_msg = MW'(sm);
    xfer_dst_mask = NCELL'(mk); xfer_dst_msg = MW'(dm);
  endtask

  task automatic run_xfer(input int s, input int sm, input int mk, input int dm,
                          output int lat, output int errs);
    int cyc = 0;
    bit got = 0;
    errs = 0;
    @(negedge clk);
    set_xfer(s, sm, mk, dm);
    for (int t = 0; t < 200 && !got; t++) begin
      @(posedge clk); @(negedge clk);
      xfer_req = 1'b0;
      cyc++;
      if (xfer_err) errs++;
      if (xfer_done) got = 1;
    end
    lat = got ? cyc - 1 : -1;
  endtask

  task automatic apply_copy(input int s, input int sm, input int mk, input int dm);
    logic [REC_W-1:0] v;
    v = shadow[s][sm];
    for (int c = 0; c < NCELL; c++) if (mk[c]) shadow[c][dm] = v;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [REC_W-1:0] rd;
    int lat, errs;
    xfer_req = 0; xfer_src = '0; xfer_src_msg = '0; xfer_dst_mask = '0; xfer_dst_msg = '0;
    cpu_req = 0; cpu_cell = '0; cpu_wr = 0; cpu_msg = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(xfer_ready === 1'b1 && xfer_done === 1'b0 && xfer_err === 1'b0 &&
          cpu_ack === 1'b0 && cell_busy === '0, "R1 in reset",
          REC_W'({xfer_ready, xfer_done, xfer_err, cpu_ack, cell_busy}), REC_W'(8'h80));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(xfer_ready === 1'b1 && xfer_done === 1'b0 && xfer_err === 1'b0 &&
          cpu_ack === 1'b0 && cell_busy === '0, "R1 after release",
          REC_W'({xfer_ready, xfer_done, xfer_err, cpu_ack, cell_busy}), REC_W'(8'h80));

    // R2: fill every record through the CPU port, then read some back
    for (int c = 0; c < NCELL; c++)
      for (int m = 0; m < NMSG; m++) cpu_write(c, m, mkrec(c * 16 + m));
    cpu_read(0, 0, rd); check(rd == shadow[0][0], "R2 read c0 m0", rd, shadow[0][0]);
    cpu_read(3, 7, rd); check(rd == shadow[3][7], "R2 read c3 m7", rd, shadow[3][7]);
    cpu_read(2, 4, rd); check(rd == shadow[2][4], "R2 read c2 m4", rd, shadow[2][4]);

    // R3 R4 R6: table of routes
    for (int v = 0; v < NVEC; v++) begin
      cpu_write(VEC[v][0], VEC[v][1], mkrec(1000 + v));
      run_xfer(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], lat, errs);
      apply_copy(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      check(lat == NOM_LAT, "R6 done latency", REC_W'(lat), REC_W'(NOM_LAT));
      check(errs == 0, "R6 no error on valid route", REC_W'(errs), '0);
      for (int c = 0; c < NCELL; c++) begin
        cpu_read(c, VEC[v][3], rd);
        check(rd == shadow[c][VEC[v][3]], VEC[v][2][c] ? "R3 destination copy" : "R4 untouched cell",
              rd, shadow[c][VEC[v][3]]);
      end
      cpu_read(VEC[v][0], VEC[v][1], rd);
      check(rd == shadow[VEC[v][0]][VEC[v][1]], "R4 source record kept", rd, shadow[VEC[v][0]][VEC[v][1]]);
    end

    // R5: empty mask
    begin
      int dn = 0;
      @(negedge clk);
      set_xfer(1, 2, 0, 3);
      @(posedge clk); @(negedge clk);
      xfer_req = 1'b0;
      check(xfer_err === 1'b1 && xfer_ready === 1'b1, "R5 error pulse",
            REC_W'({xfer_err, xfer_ready}), REC_W'(2'b11));
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (xfer_done || xfer_err) dn++;
      end
      check(dn == 0, "R5 no done, single error", REC_W'(dn), '0);
      for (int c = 0; c < NCELL; c++) begin
        cpu_read(c, 3, rd); check(rd == shadow[c][3], "R5 no cell changed", rd, shadow[c][3]);
      end
    end

    // R7: CPU read and router request collide on the source cell
    begin
      int cyc = 0, ack_at = -1, done_at = -1;
      logic [REC_W-1:0] crd = '0;
      @(negedge clk);
      set_xfer(2, 3, 4'b0001, 6);
      cpu_req = 1'b1; cpu_cell = 2'd2; cpu_wr = 1'b0; cpu_msg = 3'd4;
      for (int t = 0; t < 100 && done_at < 0; t++) begin
        @(posedge clk); @(negedge clk);
        xfer_req = 1'b0; cpu_req = 1'b0;
        cyc++;
        if (cpu_ack) begin ack_at = cyc; crd = cpu_rdata; end
        if (xfer_done) done_at = cyc;
      end
      apply_copy(2, 3, 4'b0001, 6);
      check(done_at - 1 == PRI_LAT, "R7 delayed done latency", REC_W'(done_at - 1), REC_W'(PRI_LAT));
      check(ack_at > 0 && ack_at < done_at, "R7 cpu served first", REC_W'(ack_at), REC_W'(done_at));
      check(crd == shadow[2][4], "R7 cpu read data", crd, shadow[2][4]);
      cpu_read(0, 6, rd); check(rd == shadow[0][6], "R7 transfer data", rd, shadow[0][6]);
    end

    // R8: CPU write reaches a destination in the middle of its commit
    begin
      int cyc = 0, ack_at = -1, done_at = -1;
      bit sent = 0;
      logic [REC_W-1:0] nv = mkrec(4242);
      @(negedge clk);
      set_xfer(0, 5, 4'b0100, 3);
      for (int t = 0; t < 100 && (ack_at < 0 || done_at < 0); t++) begin
        @(posedge clk); @(negedge clk);
        xfer_req = 1'b0; cpu_req = 1'b0;
        cyc++;
        if (cpu_ack) ack_at = cyc;
        if (xfer_done) done_at = cyc;
        if (!sent && cell_busy[2]) begin
          sent = 1;
          cpu_req = 1'b1; cpu_cell = 2'd2; cpu_wr = 1'b1; cpu_msg = 3'd6; cpu_wdata = nv;
        end
      end
      apply_copy(0, 5, 4'b0100, 3);
      shadow[2][6] = nv;
      check(done_at > 0 && ack_at > done_at, "R8 router op finishes first", REC_W'(ack_at), REC_W'(done_at));
      cpu_read(2, 3, rd); check(rd == shadow[2][3], "R8 transfer kept", rd, shadow[2][3]);
      cpu_read(2, 6, rd); check(rd == shadow[2][6], "R8 cpu write kept", rd, shadow[2][6]);
    end

    // R9: second request while busy is ignored
    begin
      int dn = 0;
      bit low_seen = 0;
      @(negedge clk);
      set_xfer(0, 0, 4'b0010, 4);
      @(posedge clk); @(negedge clk);
      xfer_req = 1'b0;
      @(negedge clk);
      low_seen = (xfer_ready == 1'b0);
      set_xfer(1, 1, 4'b1000, 1);
      @(posedge clk); @(negedge clk);
      xfer_req = 1'b0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (xfer_done) dn++;
      end
      apply_copy(0, 0, 4'b0010, 4);
      check(low_seen, "R9 ready low while busy", REC_W'(low_seen), REC_W'(1));
      check(dn == 1, "R9 single done", REC_W'(dn), REC_W'(1));
      cpu_read(3, 1, rd); check(rd == shadow[3][1], "R9 ignored route untouched", rd, shadow[3][1]);
      cpu_read(1, 4, rd); check(rd == shadow[1][4], "R9 first route delivered", rd, shadow[1][4]);
    end

    summary();
    $finish;
  end

endmodule